// File: doc/BRIEF.md
# Idle-Compensating Elastic Buffer

This block carries a 64-bit lane stream with an 8-bit per-byte control mask from a recovered write clock to a local read clock. The two clocks run at the same nominal frequency but may differ by a few hundred ppm. Storage is a small ring of entries. Pointers cross between the clock domains in Gray code. Each side forms its own estimate of the fill level from its own pointer and the synchronised pointer of the other side.

The block keeps the fill level near half. When the write side sees the level climbing past its upper threshold, it discards an incoming IDLE word instead of storing it. When the read side sees the level sinking below its lower threshold, it emits an extra IDLE word and holds its read pointer. Only IDLE words are ever added or removed, so the order and content of data and non-idle control words are preserved. Sticky flags report a write into a full ring and a read from an empty ring. Counters report how many words were inserted and how many were deleted.

Each side's estimate lags the true fill by about one pointer register plus the two synchroniser stages. The thresholds are therefore widened by a parameter `SLACK` (default 3). With the default 16-entry ring, the read side starts once its estimate reaches 5. The write side deletes above an estimate of 12. The read side inserts below an estimate of 4.

Top module: `idle_elastic_buffer`

## Requirements
- R1: While reset and right after it, the read port outputs the IDLE word (control mask 8'hFF and every data byte 8'h07). After reset, `rd_started` is 0, both counters are 0 and both sticky flags are 0.
- R2: After reset the read side outputs only IDLE words until its fill estimate reaches HALF-SLACK (5 by default). Reaching this level needs at least 5 words to have been written. Once `rd_started` rises it stays at 1 until read reset.
- R3: Every word that is not the IDLE word appears on the read port exactly once and in the order it was written. The only exception is a word arriving at a full ring.
- R4: The write side discards an incoming word only if the word is IDLE and its fill estimate exceeds HALF+1+SLACK (12 by default). It never discards on two successive incoming words. Each discard increments `wr_del_count`.
- R5: The read side inserts a word only if its fill estimate is below HALF-1-SLACK (4 by default) and the word at the head of the ring is IDLE. An insertion outputs IDLE without advancing the read pointer, never happens in two successive cycles, and increments `rd_ins_count`.
- R6: When the write clock is 200 ppm faster, deletions occur. When the read clock is 200 ppm faster, insertions occur. In both cases R3 still holds.
- R7: Under continuous traffic with a ±200 ppm offset, neither `wr_overflow` nor `rd_underflow` is raised.
- R8: A valid, non-deleted word that arrives while the write estimate equals the ring depth (16) is discarded. `wr_overflow` is then set and held until write reset.
- R9: If the read side finds its estimate at 0 after starting, `rd_underflow` is set and held until read reset, and the read port outputs IDLE.
- R10: A word whose control mask is 8'hFF but whose data differs from the IDLE pattern in any byte counts as a non-idle word under R3, R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Word on wr_data/wr_ctrl is present this cycle |
| wr_data | input | 64 | Incoming data word, eight byte lanes |
| wr_ctrl | input | 8 | Incoming per-byte control mask |
| rd_clk | input | 1 | Local read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_data | output | 64 | Outgoing data word (registered) |
| rd_ctrl | output | 8 | Outgoing per-byte control mask (registered) |
| rd_started | output | 1 | Read side has left its initial hold |
| rd_underflow | output | 1 | Sticky: ring found empty after start |
| rd_ins_count | output | 16 | Number of IDLE words inserted |
| wr_overflow | output | 1 | Sticky: word arrived at a full ring |
| wr_del_count | output | 16 | Number of IDLE words deleted |

## Verification
The assertions assume that the two clocks differ by at most a few hundred ppm. Under that assumption a pointer never moves by more than about one step per cycle of the other domain. They also assume that the incoming stream carries IDLE words often enough to absorb drift before the ring fills or empties. The stimulus keeps to this by driving clocks offset by exactly ±200 ppm and a stream in which about 40 percent of words are IDLE. Near-idle control words are mixed in. The only breaches of the operating range are deliberate: holding the read side in reset to fill the ring, and stopping the writer to drain it.

// File: rtl/ebuf_pkg.sv
`timescale 1ns/1ps
package ebuf_pkg;
    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam logic [LANE_W-1:0] IDLE_CODE = 8'h07;

    typedef struct packed {
        logic [LANES-1:0]  ctrl;
        logic [DATA_W-1:0] data;
    } lane_word_t;

    localparam lane_word_t IDLE_WORD = '{ctrl: {LANES{1'b1}}, data: {LANES{IDLE_CODE}}};

    function automatic logic is_idle(input lane_word_t w);
        return (w.ctrl == {LANES{1'b1}}) && (w.data == {LANES{IDLE_CODE}});
    endfunction
endpackage

// File: rtl/ebuf_gray_sync.sv
`timescale 1ns/1ps
module ebuf_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_out[i] = ^sync_q[W-1:i];
    end
endmodule

// File: rtl/ebuf_ram.sv
`timescale 1ns/1ps
module ebuf_ram
    import ebuf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  lane_word_t        wword,
    input  logic [ADDR_W-1:0] raddr,
    output lane_word_t        rword
);
    localparam int DEPTH = 1 << ADDR_W;

    lane_word_t mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wword;
    end

    assign rword = mem_q[raddr];
endmodule

// File: rtl/ebuf_wr_ctl.sv
`timescale 1ns/1ps
module ebuf_wr_ctl
    import ebuf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SLACK  = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  lane_word_t        word,
    input  logic [ADDR_W:0]   rptr_bin,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wptr_gray,
    output logic [CNT_W-1:0]  del_count,
    output logic              overflow
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
    localparam logic [PW-1:0] DEL_LVL  = PW'(DEPTH / 2 + 1 + SLACK);

    logic [PW-1:0] wptr_q;
    logic [PW-1:0] wnext;
    logic [PW-1:0] occ;
    logic          del_last_q;
    logic          idle_in;
    logic          full;
    logic          drop;

    assign occ     = wptr_q - rptr_bin;
    assign idle_in = is_idle(word);
    assign full    = (occ == FULL_LVL);
    assign drop    = valid && idle_in && !del_last_q && (occ > DEL_LVL);
    assign we      = valid && !drop && !full;
    assign wnext   = wptr_q + 1'b1;
    assign waddr   = wptr_q[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q     <= '0;
            wptr_gray  <= '0;
            del_last_q <= 1'b0;
            del_count  <= '0;
            overflow   <= 1'b0;
        end else begin
            if (we) begin
                wptr_q     <= wnext;
                wptr_gray  <= wnext ^ (wnext >> 1);
                del_last_q <= 1'b0;
            end
            if (drop) begin
                del_last_q <= 1'b1;
                del_count  <= del_count + 1'b1;
            end
            if (valid && !drop && full) overflow <= 1'b1;
        end
    end

    // R3
    nonidle_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !idle_in && !full) |=> (wptr_q == $past(wptr_q) + 1'b1));

    // R4
    drop_idle_only_chk: assert property (@(posedge clk) disable iff (rst)
        (del_count != $past(del_count)) |-> $past(valid && idle_in && (occ > DEL_LVL)));

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R8
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_LVL);
endmodule

// File: rtl/ebuf_rd_ctl.sv
`timescale 1ns/1ps
module ebuf_rd_ctl
    import ebuf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SLACK  = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W:0]   wptr_bin,
    input  lane_word_t        head,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rptr_gray,
    output lane_word_t        out_word,
    output logic              started,
    output logic [CNT_W-1:0]  ins_count,
    output logic              underflow
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] START_LVL = PW'(DEPTH / 2 - SLACK);
    localparam logic [PW-1:0] INS_LVL   = PW'(DEPTH / 2 - 1 - SLACK);

    logic [PW-1:0] rptr_q;
    logic [PW-1:0] rnext;
    logic [PW-1:0] occ;
    logic          ins_last_q;
    logic          empty;
    logic          head_idle;
    logic          insert;
    logic          pop;

    assign occ       = wptr_bin - rptr_q;
    assign empty     = (occ == '0);
    assign head_idle = is_idle(head);
    assign insert    = started && !empty && (occ < INS_LVL) && head_idle && !ins_last_q;
    assign pop       = started && !empty && !insert;
    assign rnext     = rptr_q + 1'b1;
    assign raddr     = rptr_q[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q     <= '0;
            rptr_gray  <= '0;
            started    <= 1'b0;
            ins_last_q <= 1'b0;
            ins_count  <= '0;
            underflow  <= 1'b0;
            out_word   <= IDLE_WORD;
        end else begin
            if (!started && (occ >= START_LVL)) started <= 1'b1;
            if (pop) begin
                rptr_q     <= rnext;
                rptr_gray  <= rnext ^ (rnext >> 1);
                out_word   <= head;
                ins_last_q <= 1'b0;
            end else begin
                out_word <= IDLE_WORD;
            end
            if (insert) begin
                ins_last_q <= 1'b1;
                ins_count  <= ins_count + 1'b1;
            end
            if (started && empty) underflow <= 1'b1;
        end
    end

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !started |-> is_idle(out_word));

    // R2
    started_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        started |=> started);

    // R5
    ins_holds_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_count != $past(ins_count)) |-> (rptr_q == $past(rptr_q)));

    // R5
    ins_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_count != $past(ins_count)) |-> ($past(head_idle) && is_idle(out_word)));

    // R9
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);
endmodule

// File: rtl/idle_elastic_buffer.sv
`timescale 1ns/1ps
module idle_elastic_buffer
    import ebuf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SLACK  = 3,
    parameter int CNT_W  = 16
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_valid,
    input  logic [63:0]       wr_data,
    input  logic [7:0]        wr_ctrl,
    input  logic              rd_clk,
    input  logic              rd_rst,
    output logic [63:0]       rd_data,
    output logic [7:0]        rd_ctrl,
    output logic              rd_started,
    output logic              rd_underflow,
    output logic [CNT_W-1:0]  rd_ins_count,
    output logic              wr_overflow,
    output logic [CNT_W-1:0]  wr_del_count
);
    localparam int PW = ADDR_W + 1;

    lane_word_t        wr_word;
    lane_word_t        head_word;
    lane_word_t        rd_word;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PW-1:0]     wptr_gray;
    logic [PW-1:0]     rptr_gray;
    logic [PW-1:0]     wptr_in_rd;
    logic [PW-1:0]     rptr_in_wr;

    assign wr_word = '{ctrl: wr_ctrl, data: wr_data};
    assign rd_data = rd_word.data;
    assign rd_ctrl = rd_word.ctrl;

    ebuf_wr_ctl #(.ADDR_W(ADDR_W), .SLACK(SLACK), .CNT_W(CNT_W)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .valid(wr_valid), .word(wr_word),
        .rptr_bin(rptr_in_wr), .we(we), .waddr(waddr), .wptr_gray(wptr_gray),
        .del_count(wr_del_count), .overflow(wr_overflow)
    );

    ebuf_ram #(.ADDR_W(ADDR_W)) u_ram (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wword(wr_word),
        .raddr(raddr), .rword(head_word)
    );

    ebuf_gray_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .gray_in(wptr_gray), .bin_out(wptr_in_rd)
    );

    ebuf_gray_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .gray_in(rptr_gray), .bin_out(rptr_in_wr)
    );

    ebuf_rd_ctl #(.ADDR_W(ADDR_W), .SLACK(SLACK), .CNT_W(CNT_W)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .wptr_bin(wptr_in_rd), .head(head_word),
        .raddr(raddr), .rptr_gray(rptr_gray), .out_word(rd_word),
        .started(rd_started), .ins_count(rd_ins_count), .underflow(rd_underflow)
    );
endmodule

// File: tb/sim_idle_elastic_buffer.sv
`timescale 1ns/1ps
module sim_idle_elastic_buffer;
    import ebuf_pkg::*;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst = 1'b1;
    logic        rd_rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_ctrl = '0;
    logic [63:0] rd_data;
    logic [7:0]  rd_ctrl;
    logic        rd_started;
    logic        rd_underflow;
    logic [15:0] rd_ins_count;
    logic        wr_overflow;
    logic [15:0] wr_del_count;

    realtime wr_half = 10.0;
    realtime rd_half = 10.0;

    always #(wr_half) wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    idle_elastic_buffer u0 (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ctrl(wr_ctrl), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_data(rd_data),
        .rd_ctrl(rd_ctrl), .rd_started(rd_started), .rd_underflow(rd_underflow),
        .rd_ins_count(rd_ins_count), .wr_overflow(wr_overflow), .wr_del_count(wr_del_count)
    );

    int          checks = 0;
    int          errors = 0;
    int          wr_words = 0;
    int          seq = 0;
    bit          mon_en = 1'b0;
    bit          seen_start = 1'b0;
    bit          done = 1'b0;
    logic [71:0] exp_q [$];
    localparam logic [71:0] IDLE72 = {8'hFF, {8{8'h07}}};

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge rd_clk) begin
        if (mon_en) begin
            if (!rd_started && {rd_ctrl, rd_data} != IDLE72)
                check(1'b0, "R2 output before start", {rd_ctrl, rd_data}, IDLE72);
            if (rd_started && !seen_start) begin
                seen_start = 1'b1;
                check(wr_words >= 5, "R2 start needs five written words", 72'(wr_words), 72'd5);
            end
            if ({rd_ctrl, rd_data} != IDLE72) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected non-idle word", {rd_ctrl, rd_data}, IDLE72);
                end else begin
                    logic [71:0] e;
                    e = exp_q.pop_front();
                    check({rd_ctrl, rd_data} == e, "R3 R10 word order", {rd_ctrl, rd_data}, e);
                end
            end
        end
    end

    task automatic drive_stream(input int n, input int idle_pct);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_valid = 1'b1;
            if (32'($urandom_range(99, 0)) < idle_pct) begin
                {wr_ctrl, wr_data} = IDLE72;
            end else begin
                seq++;
                if ((seq % 8) == 0) begin
                    // R10: near-idle control word, one byte differs
                    wr_ctrl = 8'hFF;
                    wr_data = {{7{8'h07}}, 8'hFD};
                end else begin
                    wr_ctrl = 8'h00;
                    wr_data = {$urandom, 32'(seq)};
                end
                exp_q.push_back({wr_ctrl, wr_data});
            end
            wr_words++;
        end
    endtask

    task automatic do_reset(input bit keep_rd);
        mon_en = 1'b0;
        @(negedge wr_clk);
        wr_valid = 1'b0;
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        repeat (4) @(negedge rd_clk);
        exp_q.delete();
        seen_start = 1'b0;
        wr_words = 0;
        @(negedge wr_clk);
        wr_rst = 1'b0;
        if (!keep_rd) begin
            @(negedge rd_clk);
            rd_rst = 1'b0;
            mon_en = 1'b1;
        end
    endtask

    initial begin
        #3500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset state, R1
        repeat (4) @(negedge rd_clk);
        check({rd_ctrl, rd_data} == IDLE72, "R1 output in reset", {rd_ctrl, rd_data}, IDLE72);
        @(negedge wr_clk);
        wr_rst = 1'b0;
        @(negedge rd_clk);
        rd_rst = 1'b0;
        repeat (3) @(negedge rd_clk);
        check({rd_ctrl, rd_data} == IDLE72, "R1 output after reset", {rd_ctrl, rd_data}, IDLE72);
        check(rd_started == 1'b0, "R1 started", 72'(rd_started), 72'd0);
        check(rd_ins_count == 0 && wr_del_count == 0, "R1 counters",
              {rd_ins_count, wr_del_count}, 72'd0);
        check(!rd_underflow && !wr_overflow, "R1 flags", {rd_underflow, wr_overflow}, 72'd0);
        mon_en = 1'b1;

        // phase A: write clock 200 ppm fast, R6 R4 R7
        wr_half = 9.998;
        drive_stream(50000, 40);
        check(wr_del_count > 0, "R4 R6 deletions with fast writer", 72'(wr_del_count), 72'd1);
        check(!wr_overflow, "R7 no overflow fast writer", 72'(wr_overflow), 72'd0);
        @(negedge rd_clk);
        check(!rd_underflow, "R7 no underflow fast writer", 72'(rd_underflow), 72'd0);
        check(exp_q.size() <= 20, "R3 backlog bounded fast writer", 72'(exp_q.size()), 72'd20);

        // phase B: read clock 200 ppm fast, R5 R6 R7
        do_reset(1'b0);
        wr_half = 10.002;
        drive_stream(50000, 40);
        @(negedge rd_clk);
        check(rd_ins_count > 0, "R5 R6 insertions with fast reader", 72'(rd_ins_count), 72'd1);
        check(!rd_underflow, "R7 no underflow fast reader", 72'(rd_underflow), 72'd0);
        check(!wr_overflow, "R7 no overflow fast reader", 72'(wr_overflow), 72'd0);

        // drain: writer stops, R3 nothing lost, R9 underflow
        @(negedge wr_clk);
        wr_valid = 1'b0;
        repeat (60) @(negedge rd_clk);
        check(exp_q.size() == 0, "R3 all words delivered", 72'(exp_q.size()), 72'd0);
        check(rd_underflow == 1'b1, "R9 underflow after drain", 72'(rd_underflow), 72'd1);
        repeat (5) @(negedge rd_clk);
        check(rd_underflow == 1'b1, "R9 underflow sticky", 72'(rd_underflow), 72'd1);
        check({rd_ctrl, rd_data} == IDLE72, "R9 idle while empty", {rd_ctrl, rd_data}, IDLE72);

        // overflow: read side held in reset, R8
        wr_half = 10.0;
        do_reset(1'b1);
        for (int i = 0; i < 16; i++) begin
            @(negedge wr_clk);
            wr_valid = 1'b1;
            wr_ctrl = 8'h00;
            wr_data = 64'(i + 100);
        end
        @(negedge wr_clk);
        wr_data = 64'd999;
        check(wr_overflow == 1'b0, "R8 no overflow at sixteen", 72'(wr_overflow), 72'd0);
        @(negedge wr_clk);
        wr_valid = 1'b0;
        check(wr_overflow == 1'b1, "R8 overflow on seventeenth", 72'(wr_overflow), 72'd1);
        repeat (5) @(negedge wr_clk);
        check(wr_overflow == 1'b1, "R8 overflow sticky", 72'(wr_overflow), 72'd1);
        check(wr_del_count == 0, "R4 no deletion of data words", 72'(wr_del_count), 72'd0);

        @(negedge wr_clk);
        wr_rst = 1'b1;
        @(negedge wr_clk);
        check(wr_overflow == 1'b0, "R8 overflow cleared by reset", 72'(wr_overflow), 72'd0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule